// File: doc/BRIEF.md
# Time-Multiplexed Shared-Memory Multi-Channel FIFO

This block builds several independent first-in first-out channels on one simple dual-port memory. Every channel has its own write clock and read clock, its own data buses, an active-low write strobe, an active-low read strobe, and its own status flags. The clocks may be unrelated to one another in frequency and phase. A separate multiplexing clock runs a fixed round-robin sequencer. It gives each channel one write slot and one read slot per rotation, so the memory bandwidth is split evenly among the channels.

Requests leave a port clock domain as a toggle. The toggle is synchronized into the multiplexing domain, and the port holds its request data stable until the acknowledge toggle has come back. While this round trip is in progress, the port's busy output is high. Occupancy is counted in the multiplexing domain. The full and empty flags derived from it are synchronized back to the ports, which makes them conservative. Each channel owns a contiguous region of the memory, DEPTH words in size, starting at channel × DEPTH. Each channel's read port is set at build time to one of two styles. In request style, data is returned only after a read strobe. In show-ahead style, the head word is already presented and the strobe acknowledges and pops it.

Top module: `tdm_multi_fifo`

## Requirements
- R1: After reset, every channel shows wr_full=0, wr_busy=0, rd_busy=0, rd_valid=0 and rd_empty=1.
- R2: Within a channel, words are read out in the order they were written, with their values unchanged.
- R3: Channels run independently with their own clocks. Concurrent traffic on several channels never delivers one channel's word to another channel.
- R4: Slots rotate in a fixed order: write of channel 0, read of channel 0, write of channel 1, and so on. A channel's write busy flag clears no later than (2·NCH+4) multiplexing-clock cycles plus four write-clock cycles after its write was accepted.
- R5: A write is accepted on a write-clock edge where wr_n=0, wr_busy=0 and wr_full=0. wr_busy is then 1 and the captured data is held until the acknowledge returns. A wr_n strobe while wr_busy=1 is ignored, and its data never reaches the channel.
- R6: A channel holds DEPTH words, after which wr_full=1. A write strobe while full is ignored: wr_busy stays 0, and neither the stored words nor the pointers change.
- R7: A read strobe on an empty channel is ignored: no rd_valid, no busy, no pointer change. A later write and read return only the newly written word.
- R8: In request style (bit c of SHOW_AHEAD_MASK = 0), rd_valid is 0 until a read is requested. Data is presented with a single-cycle rd_valid pulse some cycles after the rd_n=0 strobe.
- R9: In show-ahead style (bit c of SHOW_AHEAD_MASK = 1), the head word is presented with rd_valid=1 while rd_n is still high, and it stays stable until popped. A one-cycle rd_n=0 pops it, and rd_valid is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tdm_clk | input | 1 | Multiplexing clock for the sequencer and the memory |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_clk | input | NCH | Per-channel write clocks |
| wr_n | input | NCH | Per-channel active-low write strobes |
| wr_data | input | NCH*DW | Per-channel write data, channel c at bits c*DW +: DW |
| wr_busy | output | NCH | Write in flight; new strobes ignored |
| wr_full | output | NCH | Channel full (conservative) |
| rd_clk | input | NCH | Per-channel read clocks |
| rd_n | input | NCH | Per-channel active-low read request / acknowledge |
| rd_data | output | NCH*DW | Per-channel read data |
| rd_valid | output | NCH | Read data valid (pulse or held head word, per style) |
| rd_empty | output | NCH | No word available to the read port (conservative) |
| rd_busy | output | NCH | Read fetch in flight |

## Verification
Several checks run on every cycle. The occupancy counter never goes beyond DEPTH. A write served against a full count, or a read served against an empty count, leaves its pointer untouched. A pending request is served within one slot rotation. A write port never changes its captured data while busy. Request-style valid is a single-cycle pulse, and a show-ahead head word does not move while it waits for its acknowledge. End-to-end properties can only be shown by the directed scenarios: ordering, separation between channels under concurrent traffic with unrelated clocks, the fact that a strobe while busy or full leaves no trace in the data, and the absence of phantom words after an empty read.

// File: rtl/tdmf_pkg.sv
`timescale 1ns/1ps
package tdmf_pkg;
   // Read-side presentation style of one channel
   typedef enum logic {
      RD_REQUEST   = 1'b0,
      RD_SHOWAHEAD = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/tdmf_sync2.sv
`timescale 1ns/1ps
module tdmf_sync2 #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {2{RST_VAL}};
      else        stg <= {stg[0], d};
   end

   assign q = stg[1];
endmodule

// File: rtl/tdmf_wr_port.sv
`timescale 1ns/1ps
module tdmf_wr_port #(
   parameter int unsigned DW = 8
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_n,
   input  logic [DW-1:0] wr_data,
   input  logic          full_a,
   input  logic          ack_a,
   output logic          req_t,
   output logic [DW-1:0] wdat,
   output logic          busy,
   output logic          full
);
   logic ack_s;

   tdmf_sync2 #(.RST_VAL(1'b0)) u_ack  (.clk(wclk), .rst_n(rst_n), .d(ack_a),  .q(ack_s));
   tdmf_sync2 #(.RST_VAL(1'b0)) u_full (.clk(wclk), .rst_n(rst_n), .d(full_a), .q(full));

   // request outstanding while the returned toggle has not caught up
   assign busy = req_t ^ ack_s;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         req_t <= 1'b0;
         wdat  <= '0;
      end else if (!wr_n && !busy && !full) begin
         req_t <= ~req_t;
         wdat  <= wr_data;
      end
   end

   AST_WDATA_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
      busy |=> $stable(wdat)); // R5
endmodule

// File: rtl/tdmf_rd_port.sv
`timescale 1ns/1ps
module tdmf_rd_port #(
   parameter int unsigned        DW   = 8,
   parameter tdmf_pkg::rd_mode_e MODE = tdmf_pkg::RD_REQUEST
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_n,
   input  logic          empty_a,
   input  logic          ack_a,
   input  logic [DW-1:0] rdat_a,
   input  logic          rok_a,
   output logic          req_t,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          rd_empty,
   output logic          busy
);
   logic ack_s, ack_q, empty_s, ack_ev;

   tdmf_sync2 #(.RST_VAL(1'b0)) u_ack   (.clk(rclk), .rst_n(rst_n), .d(ack_a),   .q(ack_s));
   tdmf_sync2 #(.RST_VAL(1'b1)) u_empty (.clk(rclk), .rst_n(rst_n), .d(empty_a), .q(empty_s));

   assign busy   = req_t ^ ack_s;
   assign ack_ev = ack_s ^ ack_q;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack_s;
   end

   generate
      if (MODE == tdmf_pkg::RD_SHOWAHEAD) begin : g_show
         logic head_v;

         always_ff @(posedge rclk or negedge rst_n) begin
            if (!rst_n) begin
               head_v  <= 1'b0;
               req_t   <= 1'b0;
               rd_data <= '0;
            end else begin
               if (ack_ev && rok_a) begin
                  head_v  <= 1'b1;
                  rd_data <= rdat_a;
               end else if (head_v && !rd_n) begin
                  head_v  <= 1'b0;
               end
               // prefetch the next head word as soon as the slot is free
               if (!head_v && !busy && !ack_ev && !empty_s)
                  req_t <= ~req_t;
            end
         end

         assign rd_valid = head_v;
         assign rd_empty = !head_v;

         AST_HEAD_HELD: assert property (@(posedge rclk) disable iff (!rst_n)
            (rd_valid && rd_n) |=> (rd_valid && $stable(rd_data))); // R9
      end else begin : g_req
         always_ff @(posedge rclk or negedge rst_n) begin
            if (!rst_n) begin
               req_t    <= 1'b0;
               rd_data  <= '0;
               rd_valid <= 1'b0;
            end else begin
               rd_valid <= ack_ev && rok_a;
               if (ack_ev && rok_a) rd_data <= rdat_a;
               if (!rd_n && !busy && !empty_s) req_t <= ~req_t;
            end
         end

         assign rd_empty = empty_s;

         AST_VALID_PULSE: assert property (@(posedge rclk) disable iff (!rst_n)
            rd_valid |=> !rd_valid); // R8
      end
   endgenerate
endmodule

// File: rtl/tdmf_core.sv
`timescale 1ns/1ps
module tdmf_core #(
   parameter int unsigned NCH   = 4,
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic              tdm_clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    wreq_t,
   input  logic [NCH*DW-1:0] wdat,
   output logic [NCH-1:0]    wack_t,
   input  logic [NCH-1:0]    rreq_t,
   output logic [NCH-1:0]    rack_t,
   output logic [NCH*DW-1:0] rdat,
   output logic [NCH-1:0]    rok,
   output logic [NCH-1:0]    full,
   output logic [NCH-1:0]    empty
);
   localparam int unsigned NSLOT = 2 * NCH;
   localparam int unsigned SW    = $clog2(NSLOT);
   localparam int unsigned CHW   = $clog2(NCH);
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned CW    = $clog2(DEPTH + 1);
   localparam int unsigned MW    = $clog2(NCH * DEPTH);
   localparam int unsigned NWRD  = NCH * DEPTH;

   function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   // ---- slot sequencer: even slot = write, odd slot = read of channel slot/2
   logic [SW-1:0]  slot;
   logic [CHW-1:0] sch;
   logic           slot_rd;

   always_ff @(posedge tdm_clk or negedge rst_n) begin
      if (!rst_n)                       slot <= '0;
      else if (slot == SW'(NSLOT - 1))  slot <= '0;
      else                              slot <= slot + 1'b1;
   end

   assign sch     = slot[SW-1:1];
   assign slot_rd = slot[0];

   // ---- request toggles into this domain
   logic [NCH-1:0]    wreq_s, rreq_s, do_w, do_r;
   logic [NCH*AW-1:0] wptr_flat, rptr_flat;

   // ---- shared memory
   logic [DW-1:0] mem [NWRD];
   logic [MW-1:0] mem_wa, mem_ra;
   logic [DW-1:0] mem_q;

   assign mem_wa = MW'(sch) * MW'(DEPTH) + MW'(wptr_flat[sch*AW +: AW]);
   assign mem_ra = MW'(sch) * MW'(DEPTH) + MW'(rptr_flat[sch*AW +: AW]);
   assign mem_q  = mem[mem_ra];

   always_ff @(posedge tdm_clk) begin
      if (|do_w) mem[mem_wa] <= wdat[sch*DW +: DW];
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic [AW-1:0] wptr, rptr;
         logic [CW-1:0] cnt, cnt_nxt;
         logic          w_sel, r_sel, w_pend, r_pend;
         logic          wack_q, rack_q, rok_q, full_q, empty_q;
         logic [DW-1:0] rdat_q;
         logic [SW:0]   wwait;

         tdmf_sync2 #(.RST_VAL(1'b0)) u_ws (.clk(tdm_clk), .rst_n(rst_n), .d(wreq_t[c]), .q(wreq_s[c]));
         tdmf_sync2 #(.RST_VAL(1'b0)) u_rs (.clk(tdm_clk), .rst_n(rst_n), .d(rreq_t[c]), .q(rreq_s[c]));

         assign w_sel   = (sch == CHW'(c)) && !slot_rd;
         assign r_sel   = (sch == CHW'(c)) &&  slot_rd;
         assign w_pend  = wreq_s[c] ^ wack_q;
         assign r_pend  = rreq_s[c] ^ rack_q;
         assign do_w[c] = w_sel && w_pend && (cnt != CW'(DEPTH));
         assign do_r[c] = r_sel && r_pend && (cnt != '0);

         always_comb begin
            cnt_nxt = cnt;
            if (do_w[c]) cnt_nxt = cnt + 1'b1;
            if (do_r[c]) cnt_nxt = cnt - 1'b1;
         end

         always_ff @(posedge tdm_clk or negedge rst_n) begin
            if (!rst_n) begin
               wptr    <= '0;
               rptr    <= '0;
               cnt     <= '0;
               wack_q  <= 1'b0;
               rack_q  <= 1'b0;
               rok_q   <= 1'b0;
               rdat_q  <= '0;
               full_q  <= 1'b0;
               empty_q <= 1'b1;
            end else begin
               cnt     <= cnt_nxt;
               full_q  <= (cnt_nxt == CW'(DEPTH));
               empty_q <= (cnt_nxt == '0);
               if (w_sel && w_pend) wack_q <= ~wack_q;
               if (do_w[c])         wptr   <= ptr_step(wptr);
               if (r_sel && r_pend) begin
                  rack_q <= ~rack_q;
                  rok_q  <= do_r[c];
               end
               if (do_r[c]) begin
                  rptr   <= ptr_step(rptr);
                  rdat_q <= mem_q;
               end
            end
         end

         // cycles a write request has waited for its slot
         always_ff @(posedge tdm_clk or negedge rst_n) begin
            if (!rst_n)                      wwait <= '0;
            else if (!w_pend || w_sel)       wwait <= '0;
            else                             wwait <= wwait + 1'b1;
         end

         assign wptr_flat[c*AW +: AW] = wptr;
         assign rptr_flat[c*AW +: AW] = rptr;
         assign wack_t[c]             = wack_q;
         assign rack_t[c]             = rack_q;
         assign rok[c]                = rok_q;
         assign rdat[c*DW +: DW]      = rdat_q;
         assign full[c]               = full_q;
         assign empty[c]              = empty_q;

         AST_NO_OVERFLOW: assert property (@(posedge tdm_clk) disable iff (!rst_n)
            (w_sel && w_pend && cnt == CW'(DEPTH)) |=> $stable(wptr)); // R6
         AST_NO_UNDERFLOW: assert property (@(posedge tdm_clk) disable iff (!rst_n)
            (r_sel && r_pend && cnt == '0) |=> ($stable(rptr) && !rok_q)); // R7
         AST_CNT_LIMIT: assert property (@(posedge tdm_clk) disable iff (!rst_n)
            cnt <= CW'(DEPTH)); // R6
         AST_SLOT_BOUND: assert property (@(posedge tdm_clk) disable iff (!rst_n)
            wwait < (SW+1)'(NSLOT)); // R4
      end
   endgenerate
endmodule

// File: rtl/tdm_multi_fifo.sv
`timescale 1ns/1ps
module tdm_multi_fifo #(
   parameter int unsigned NCH             = 4,
   parameter int unsigned DW              = 8,
   parameter int unsigned DEPTH           = 8,
   parameter int unsigned SHOW_AHEAD_MASK = 32'hA
) (
   input  logic              tdm_clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    wr_clk,
   input  logic [NCH-1:0]    wr_n,
   input  logic [NCH*DW-1:0] wr_data,
   output logic [NCH-1:0]    wr_busy,
   output logic [NCH-1:0]    wr_full,
   input  logic [NCH-1:0]    rd_clk,
   input  logic [NCH-1:0]    rd_n,
   output logic [NCH*DW-1:0] rd_data,
   output logic [NCH-1:0]    rd_valid,
   output logic [NCH-1:0]    rd_empty,
   output logic [NCH-1:0]    rd_busy
);
   // ---- elaboration-time parameter checks
   if (NCH < 2 || NCH > 32) begin : g_bad_nch
      $error("tdm_multi_fifo: NCH must lie in 2..32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("tdm_multi_fifo: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("tdm_multi_fifo: DW must be at least 1");
   end

   logic [NCH-1:0]    wreq_t, wack_t, rreq_t, rack_t, rok, c_full, c_empty;
   logic [NCH*DW-1:0] wdat, rdat;

   tdmf_core #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_core (
      .tdm_clk (tdm_clk),
      .rst_n   (rst_n),
      .wreq_t  (wreq_t),
      .wdat    (wdat),
      .wack_t  (wack_t),
      .rreq_t  (rreq_t),
      .rack_t  (rack_t),
      .rdat    (rdat),
      .rok     (rok),
      .full    (c_full),
      .empty   (c_empty)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_port
         localparam tdmf_pkg::rd_mode_e MODE_C =
            ((SHOW_AHEAD_MASK >> c) & 1) != 0 ? tdmf_pkg::RD_SHOWAHEAD : tdmf_pkg::RD_REQUEST;

         tdmf_wr_port #(.DW(DW)) u_wr (
            .wclk    (wr_clk[c]),
            .rst_n   (rst_n),
            .wr_n    (wr_n[c]),
            .wr_data (wr_data[c*DW +: DW]),
            .full_a  (c_full[c]),
            .ack_a   (wack_t[c]),
            .req_t   (wreq_t[c]),
            .wdat    (wdat[c*DW +: DW]),
            .busy    (wr_busy[c]),
            .full    (wr_full[c])
         );

         tdmf_rd_port #(.DW(DW), .MODE(MODE_C)) u_rd (
            .rclk     (rd_clk[c]),
            .rst_n    (rst_n),
            .rd_n     (rd_n[c]),
            .empty_a  (c_empty[c]),
            .ack_a    (rack_t[c]),
            .rdat_a   (rdat[c*DW +: DW]),
            .rok_a    (rok[c]),
            .req_t    (rreq_t[c]),
            .rd_data  (rd_data[c*DW +: DW]),
            .rd_valid (rd_valid[c]),
            .rd_empty (rd_empty[c]),
            .busy     (rd_busy[c])
         );
      end
   endgenerate
endmodule

// File: tb/tb_tdm_multi_fifo.sv
`timescale 1ns/1ps
module tb_tdm_multi_fifo;
   localparam int NCH   = 4;
   localparam int DW    = 8;
   localparam int DEPTH = 4;
   localparam int TDM_P = 4;
   localparam int WD_NS = 400000;

   logic              tdm_clk = 1'b0;
   logic              rst_n   = 1'b0;
   logic [NCH-1:0]    wclk, rclk;
   logic [NCH-1:0]    wr_n = '1;
   logic [NCH-1:0]    rd_n = '1;
   logic [NCH*DW-1:0] wr_data = '0;
   logic [NCH-1:0]    wr_busy, wr_full, rd_valid, rd_empty, rd_busy;
   logic [NCH*DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #(TDM_P/2) tdm_clk = ~tdm_clk;

   function automatic int wper(int c); return 10 + 4*c; endfunction
   function automatic int rper(int c); return 12 + 4*c; endfunction

   for (genvar c = 0; c < NCH; c++) begin : g_clk
      logic wk = 1'b0, rk = 1'b0;
      initial forever #(wper(c)/2) wk = ~wk;
      initial forever #(rper(c)/2) rk = ~rk;
      assign wclk[c] = wk;
      assign rclk[c] = rk;
   end

   // channels 1 and 3 show-ahead, 0 and 2 request style
   tdm_multi_fifo #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .SHOW_AHEAD_MASK(32'hA)) dut (
      .tdm_clk (tdm_clk), .rst_n (rst_n),
      .wr_clk (wclk), .wr_n (wr_n), .wr_data (wr_data),
      .wr_busy (wr_busy), .wr_full (wr_full),
      .rd_clk (rclk), .rd_n (rd_n), .rd_data (rd_data),
      .rd_valid (rd_valid), .rd_empty (rd_empty), .rd_busy (rd_busy)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int ch, input logic [DW-1:0] d);
      int n;
      int lim;
      lim = ((2*NCH+4)*TDM_P + wper(ch) - 1) / wper(ch) + 4;
      @(negedge wclk[ch]);
      n = 0;
      while ((wr_busy[ch] || wr_full[ch]) && n < 400) begin @(negedge wclk[ch]); n++; end
      chk(n < 400, "R6", "write port never freed", n, 0);
      wr_data[ch*DW +: DW] = d;
      wr_n[ch] = 1'b0;
      @(negedge wclk[ch]);
      wr_n[ch] = 1'b1;
      chk(wr_busy[ch] == 1'b1, "R5", "busy after accepted write", int'(wr_busy[ch]), 1);
      n = 0;
      while (wr_busy[ch] && n < 100) begin @(negedge wclk[ch]); n++; end
      chk(n <= lim, "R4", "write service latency (port cycles)", n, lim);
   endtask

   task automatic pop_req(input int ch, input logic [DW-1:0] exp, input string req);
      int n;
      @(negedge rclk[ch]);
      n = 0;
      while ((rd_empty[ch] || rd_busy[ch]) && n < 400) begin @(negedge rclk[ch]); n++; end
      chk(n < 400, req, "word never became readable", n, 0);
      chk(rd_valid[ch] == 1'b0, "R8", "valid before read request", int'(rd_valid[ch]), 0);
      rd_n[ch] = 1'b0;
      @(negedge rclk[ch]);
      rd_n[ch] = 1'b1;
      n = 0;
      while (!rd_valid[ch] && n < 100) begin @(negedge rclk[ch]); n++; end
      chk(rd_valid[ch] == 1'b1, "R8", "valid after read request", int'(rd_valid[ch]), 1);
      chk(rd_data[ch*DW +: DW] == exp, req, "request-style read data", int'(rd_data[ch*DW +: DW]), int'(exp));
      @(negedge rclk[ch]);
      chk(rd_valid[ch] == 1'b0, "R8", "valid is a single-cycle pulse", int'(rd_valid[ch]), 0);
   endtask

   task automatic pop_sa(input int ch, input logic [DW-1:0] exp, input string req);
      int n;
      @(negedge rclk[ch]);
      n = 0;
      while (!rd_valid[ch] && n < 400) begin @(negedge rclk[ch]); n++; end
      chk(rd_valid[ch] == 1'b1, "R9", "head presented without strobe", int'(rd_valid[ch]), 1);
      chk(rd_data[ch*DW +: DW] == exp, req, "show-ahead head data", int'(rd_data[ch*DW +: DW]), int'(exp));
      rd_n[ch] = 1'b0;
      @(negedge rclk[ch]);
      rd_n[ch] = 1'b1;
      chk(rd_valid[ch] == 1'b0, "R9", "head cleared after pop", int'(rd_valid[ch]), 0);
   endtask

   task automatic t_reset;
      chk(wr_full  == '0, "R1", "wr_full after reset",  int'(wr_full),  0);
      chk(wr_busy  == '0, "R1", "wr_busy after reset",  int'(wr_busy),  0);
      chk(rd_busy  == '0, "R1", "rd_busy after reset",  int'(rd_busy),  0);
      chk(rd_valid == '0, "R1", "rd_valid after reset", int'(rd_valid), 0);
      chk(rd_empty == '1, "R1", "rd_empty after reset", int'(rd_empty), 15);
   endtask

   task automatic t_order;   // R2 on a request-style channel
      push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
      pop_req(0, 8'h11, "R2"); pop_req(0, 8'h22, "R2"); pop_req(0, 8'h33, "R2");
   endtask

   task automatic t_show;    // R9 on a show-ahead channel
      push(1, 8'hA1); push(1, 8'hA2);
      pop_sa(1, 8'hA1, "R9"); pop_sa(1, 8'hA2, "R9");
   endtask

   task automatic t_full;    // R6
      for (int i = 0; i < DEPTH; i++) push(2, 8'h40 + 8'(i));
      chk(wr_full[2] == 1'b1, "R6", "full after DEPTH writes", int'(wr_full[2]), 1);
      @(negedge wclk[2]);
      wr_data[2*DW +: DW] = 8'hEE;
      wr_n[2] = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge wclk[2]);
         chk(wr_busy[2] == 1'b0, "R6", "write strobe while full not taken", int'(wr_busy[2]), 0);
      end
      wr_n[2] = 1'b1;
      for (int i = 0; i < DEPTH; i++) pop_req(2, 8'h40 + 8'(i), "R6");
      repeat (20) @(negedge rclk[2]);
      chk(rd_empty[2] == 1'b1, "R6", "empty after draining, no extra word", int'(rd_empty[2]), 1);
   endtask

   task automatic t_empty;   // R7
      int bad;
      bad = 0;
      @(negedge rclk[0]);
      rd_n[0] = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge rclk[0]);
         if (rd_valid[0] || rd_busy[0]) bad++;
      end
      rd_n[0] = 1'b1;
      chk(bad == 0, "R7", "read strobe on empty channel had an effect", bad, 0);
      push(0, 8'h5A);
      pop_req(0, 8'h5A, "R7");
      repeat (20) @(negedge rclk[0]);
      chk(rd_empty[0] == 1'b1, "R7", "no phantom word after empty read", int'(rd_empty[0]), 1);
   endtask

   task automatic t_busy;    // R5
      int n;
      @(negedge wclk[3]);
      wr_data[3*DW +: DW] = 8'hC1;
      wr_n[3] = 1'b0;
      @(negedge wclk[3]);
      chk(wr_busy[3] == 1'b1, "R5", "busy during handshake", int'(wr_busy[3]), 1);
      wr_data[3*DW +: DW] = 8'hD2;
      @(negedge wclk[3]);
      wr_n[3] = 1'b1;
      n = 0;
      while (wr_busy[3] && n < 100) begin @(negedge wclk[3]); n++; end
      pop_sa(3, 8'hC1, "R5");
      repeat (30) @(negedge rclk[3]);
      chk(rd_valid[3] == 1'b0, "R5", "strobe while busy left no word", int'(rd_valid[3]), 0);
   endtask

   task automatic t_indep;   // R3
      fork
         begin push(0, 8'h31); push(0, 8'h32); end
         begin push(2, 8'h71); push(2, 8'h72); end
         begin push(1, 8'h91); end
         begin push(3, 8'hB1); end
      join
      fork
         begin pop_req(0, 8'h31, "R3"); pop_req(0, 8'h32, "R3"); end
         begin pop_req(2, 8'h71, "R3"); pop_req(2, 8'h72, "R3"); end
         begin pop_sa(1, 8'h91, "R3"); end
         begin pop_sa(3, 8'hB1, "R3"); end
      join
   endtask

   initial begin
      #101;
      rst_n = 1'b1;
      #200;
      t_reset();
      t_order();
      t_show();
      t_full();
      t_empty();
      t_busy();
      t_indep();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(WD_NS);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule